// File: doc/BRIEF.md
# Event Timer Main Counter and Global Control

This block is the shared core of a multi-timer event timer. It owns the free-running main counter, the two global control bits and the per-timer interrupt status word. It turns the per-timer requests into a set of interrupt lines. The comparator logic sits outside the block. Each comparator reports to this block through a fire strobe, its trigger type, its interrupt enable and its requested line number.

Software reaches the block through a simple register port. It enables or halts the counter, preloads the counter in halves or as a whole word, and clears status bits by writing ones. A legacy routing mode takes over the lines of timers 0 and 1 and fixes them to lines 0 and 8. In that mode the two legacy pass-through inputs are masked, and a legacy-enable output tells the rest of the system that the old interval sources are switched off.

Top module: `evt_main_ctrl`

## Requirements
- R1: The configuration register (reg_sel 0) holds only bit 0 (global enable) and bit 1 (legacy routing). All other bits read as zero and ignore writes. A write with reg_part 2 (upper half only) leaves both bits unchanged.
- R2: While enabled, the counter advances by one every TICK_DIV clock cycles. The prescaler restarts when enable rises. A read of the counter (reg_sel 2) returns the live count.
- R3: When enable falls, the counter keeps the value it had just before that edge. A read returns that held value for as long as the counter is halted. When enable rises, counting resumes from the held value.
- R4: A counter write with reg_part 0 or 3 replaces the whole word. reg_part 1 replaces bits [31:0] from wdata[31:0]. reg_part 2 replaces bits [63:32] from wdata[63:32]. A write while running does not alter the live count, and the next disable overwrites that write with the live value.
- R5: Status bit n (reg_sel 1) is set when tmr_fire[n] is high with tmr_level[n] high. An edge-type fire (tmr_level[n] low) never sets it. The setting does not depend on the enables.
- R6: Writing status with data bit n = 1 clears bit n, and that timer's level request drops. Data bits that are 0 leave their status bits unchanged.
- R7: Each line is the OR of the timer requests routed to it. A level request is status[n] AND tmr_int_en[n] AND the global enable. An edge-type fire with interrupt and global enable set gives a one-cycle pulse. Lines change on the second clock edge after their cause.
- R8: When the global enable rises, every timer with status set and interrupt enable set drives its line again. While disabled, those lines stay low and the status is kept.
- R9: In legacy routing, timer 0 drives line 0 and timer 1 drives line 8, whatever their route fields hold. Timers 2 and up keep their own routes.
- R10: Outside legacy routing, leg_in0 is ORed onto line 0 and leg_in1 onto line 8. In legacy routing both inputs are masked. The leg_in1 level is latched at all times, so leaving legacy routing restores line 8 to the latest leg_in1 level.
- R11: leg_ena is the inverse of the legacy routing bit and follows it one clock edge later.
- R12: Reset clears the counter, both configuration bits, the status and the latched legacy levels, and it sets leg_ena high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 config, 1 status, 2 counter |
| reg_part | input | 2 | 0/3 full word, 1 lower half, 2 upper half |
| reg_wdata | input | CNT_W | Write data, halves in their word positions |
| rd_sel | input | 2 | Read target, same coding as reg_sel |
| rd_data | output | CNT_W | Registered read data, one edge after rd_sel |
| tmr_fire | input | NUM_TMR | Per-timer fire strobes |
| tmr_level | input | NUM_TMR | Per-timer trigger type, 1 = level |
| tmr_int_en | input | NUM_TMR | Per-timer interrupt enable |
| tmr_route | input | NUM_TMR*LINE_W | Per-timer line number, timer n at [n*LINE_W +: LINE_W] |
| leg_in0 | input | 1 | Legacy pass-through source for line 0 |
| leg_in1 | input | 1 | Legacy pass-through source for line 8 |
| irq_line | output | NUM_LINES | Registered interrupt lines |
| leg_ena | output | 1 | High while legacy routing is off |

## Verification
The bench builds the block with four timers, a prescaler of three and a 64-bit counter. With four timers, two timers outside the legacy pair can share a line while timers 0 and 1 are redirected. With a prescaler of three, the counter does not tick on every cycle, so the expected counts after enable, disable and resume depend on the exact edge of each transition. The counter is preloaded just below a 32-bit boundary, so the run carries from the lower half into the upper half after separate half writes.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PART_FULL = 2'd0,
    PART_LO   = 2'd1,
    PART_HI   = 2'd2,
    PART_ALL  = 2'd3
  } reg_part_e;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W    = 64,
  parameter int TICK_DIV = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             en_rise,
  input  logic             en_fall,
  input  logic             wr,
  input  logic [1:0]       part,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_value,
  output logic [CNT_W-1:0] cnt_live,
  output logic [CNT_W-1:0] cnt_held,
  output logic             cnt_tick
);
  import evt_pkg::*;

  localparam int HALF  = CNT_W / 2;
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] merged;

  assign cnt_tick = (div_q == DIV_W'(TICK_DIV - 1));

  always_comb begin
    merged = cnt_held;
    if (part != PART_HI) merged[HALF-1:0]     = wdata[HALF-1:0];
    if (part != PART_LO) merged[CNT_W-1:HALF] = wdata[CNT_W-1:HALF];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      cnt_live <= '0;
    end else if (en_rise) begin
      div_q    <= '0;
      cnt_live <= cnt_held;
    end else if (run) begin
      if (cnt_tick) begin
        div_q    <= '0;
        cnt_live <= cnt_live + CNT_W'(1);
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_held <= '0;
    else if (en_fall) cnt_held <= cnt_live;
    else if (wr)      cnt_held <= merged;
  end

  assign cnt_value = run ? cnt_live : cnt_held;
endmodule

// File: rtl/evt_status.sv
module evt_status #(
  parameter int NUM_TMR = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_en,
  input  logic [NUM_TMR-1:0] clr_mask,
  input  logic [NUM_TMR-1:0] fire,
  input  logic [NUM_TMR-1:0] level,
  input  logic [NUM_TMR-1:0] int_en,
  output logic [NUM_TMR-1:0] status_q,
  output logic [NUM_TMR-1:0] req
);
  logic [NUM_TMR-1:0] pulse_q;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    always_ff @(posedge clk) begin
      if (rst) begin
        status_q[t] <= 1'b0;
        pulse_q[t]  <= 1'b0;
      end else begin
        if (fire[t] && level[t]) status_q[t] <= 1'b1;
        else if (clr_mask[t])    status_q[t] <= 1'b0;
        pulse_q[t] <= fire[t] && !level[t] && int_en[t] && glb_en;
      end
    end
    assign req[t] = (status_q[t] && int_en[t] && glb_en) || pulse_q[t];
  end
endmodule

// File: rtl/evt_router.sv
module evt_router #(
  parameter int NUM_TMR   = 3,
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = 5,
  parameter int LEG_A     = 0,
  parameter int LEG_B     = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      legacy,
  input  logic [NUM_TMR-1:0]        req,
  input  logic [NUM_TMR*LINE_W-1:0] route,
  input  logic                      leg_in0,
  input  logic                      leg_in1,
  output logic [NUM_LINES-1:0]      irq_line,
  output logic                      leg_ena
);
  logic [LINE_W-1:0]    route_a [NUM_TMR];
  logic [NUM_LINES-1:0] line_nxt;
  logic                 leg0_q;
  logic                 leg1_q;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_unpack
    assign route_a[t] = route[t*LINE_W +: LINE_W];
  end

  function automatic logic [LINE_W-1:0] eff_route(input int t, input logic lg,
                                                   input logic [LINE_W-1:0] own);
    if (lg && t == 0)      return LINE_W'(LEG_A);
    else if (lg && t == 1) return LINE_W'(LEG_B);
    else                   return own;
  endfunction

  always_comb begin
    line_nxt = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (req[t]) line_nxt[eff_route(t, legacy, route_a[t])] = 1'b1;
    end
    if (!legacy) begin
      line_nxt[LEG_A] = line_nxt[LEG_A] | leg0_q;
      line_nxt[LEG_B] = line_nxt[LEG_B] | leg1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      leg0_q   <= 1'b0;
      leg1_q   <= 1'b0;
      irq_line <= '0;
      leg_ena  <= 1'b1;
    end else begin
      leg0_q   <= leg_in0;
      leg1_q   <= leg_in1;
      irq_line <= line_nxt;
      leg_ena  <= !legacy;
    end
  end
endmodule

// File: rtl/evt_main_ctrl.sv
module evt_main_ctrl #(
  parameter int NUM_TMR   = 3,
  parameter int CNT_W     = 64,
  parameter int TICK_DIV  = 1,
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_wr,
  input  logic [1:0]                reg_sel,
  input  logic [1:0]                reg_part,
  input  logic [CNT_W-1:0]          reg_wdata,
  input  logic [1:0]                rd_sel,
  output logic [CNT_W-1:0]          rd_data,
  input  logic [NUM_TMR-1:0]        tmr_fire,
  input  logic [NUM_TMR-1:0]        tmr_level,
  input  logic [NUM_TMR-1:0]        tmr_int_en,
  input  logic [NUM_TMR*LINE_W-1:0] tmr_route,
  input  logic                      leg_in0,
  input  logic                      leg_in1,
  output logic [NUM_LINES-1:0]      irq_line,
  output logic                      leg_ena
);
  import evt_pkg::*;

  localparam int LEG_A = 0;
  localparam int LEG_B = 8;

  logic             cfg_en, cfg_leg;
  logic             cfg_wr_lo, en_rise, en_fall, cnt_wr, stat_wr;
  logic [NUM_TMR-1:0] clr_mask, status_q, req;
  logic [CNT_W-1:0] cnt_value, cnt_live, cnt_held;
  logic             cnt_tick;

  assign cfg_wr_lo = reg_wr && (reg_sel == SEL_CFG)  && (reg_part != PART_HI);
  assign stat_wr   = reg_wr && (reg_sel == SEL_STAT) && (reg_part != PART_HI);
  assign cnt_wr    = reg_wr && (reg_sel == SEL_CNT);
  assign en_rise   = cfg_wr_lo && reg_wdata[0] && !cfg_en;
  assign en_fall   = cfg_wr_lo && !reg_wdata[0] && cfg_en;
  assign clr_mask  = stat_wr ? reg_wdata[NUM_TMR-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en  <= 1'b0;
      cfg_leg <= 1'b0;
    end else if (cfg_wr_lo) begin
      cfg_en  <= reg_wdata[0];
      cfg_leg <= reg_wdata[1];
    end
  end

  evt_counter #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_cnt (
    .clk(clk), .rst(rst), .run(cfg_en), .en_rise(en_rise), .en_fall(en_fall),
    .wr(cnt_wr), .part(reg_part), .wdata(reg_wdata), .cnt_value(cnt_value),
    .cnt_live(cnt_live), .cnt_held(cnt_held), .cnt_tick(cnt_tick)
  );

  evt_status #(.NUM_TMR(NUM_TMR)) u_stat (
    .clk(clk), .rst(rst), .glb_en(cfg_en), .clr_mask(clr_mask), .fire(tmr_fire),
    .level(tmr_level), .int_en(tmr_int_en), .status_q(status_q), .req(req)
  );

  evt_router #(.NUM_TMR(NUM_TMR), .NUM_LINES(NUM_LINES), .LINE_W(LINE_W),
               .LEG_A(LEG_A), .LEG_B(LEG_B)) u_route (
    .clk(clk), .rst(rst), .legacy(cfg_leg), .req(req), .route(tmr_route),
    .leg_in0(leg_in0), .leg_in1(leg_in1), .irq_line(irq_line), .leg_ena(leg_ena)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_sel)
        SEL_CFG:  rd_data <= {{(CNT_W-2){1'b0}}, cfg_leg, cfg_en};
        SEL_STAT: rd_data <= CNT_W'(status_q);
        SEL_CNT:  rd_data <= cnt_value;
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_main_ctrl_chk.sv
module evt_main_ctrl_chk #(
  parameter int NUM_TMR = 3,
  parameter int CNT_W   = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_en,
  input logic               cfg_leg,
  input logic               en_rise,
  input logic               cnt_tick,
  input logic               cnt_wr,
  input logic [CNT_W-1:0]   cnt_live,
  input logic [CNT_W-1:0]   cnt_held,
  input logic [NUM_TMR-1:0] status_q,
  input logic [NUM_TMR-1:0] clr_mask,
  input logic [NUM_TMR-1:0] tmr_fire,
  input logic [NUM_TMR-1:0] tmr_level,
  input logic               leg_ena
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !en_rise && cnt_tick) |=> (cnt_live == $past(cnt_live) + CNT_W'(1)));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !cnt_wr) |=> $stable(cnt_held));

  // R3
  cnt_resume_chk: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> (cnt_live == $past(cnt_held)));

  // R5
  stat_set_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status_q & ~$past(status_q) & ~$past(tmr_fire & tmr_level)) == '0));

  // R6
  stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(clr_mask) & ~$past(tmr_fire & tmr_level)) == '0));

  // R11
  leg_ena_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (leg_ena == !$past(cfg_leg)));

  // R12
  rst_val_chk: assert property (@(posedge clk)
    rst |=> (cnt_live == '0 && cnt_held == '0 && leg_ena && !cfg_en && status_q == '0));
endmodule

bind evt_main_ctrl evt_main_ctrl_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_leg(cfg_leg), .en_rise(en_rise),
  .cnt_tick(cnt_tick), .cnt_wr(cnt_wr), .cnt_live(cnt_live), .cnt_held(cnt_held),
  .status_q(status_q), .clr_mask(clr_mask), .tmr_fire(tmr_fire),
  .tmr_level(tmr_level), .leg_ena(leg_ena)
);

// File: tb/evt_main_ctrl_tb_top.sv
module evt_main_ctrl_tb_top;
  localparam int NT = 4;
  localparam int CW = 64;
  localparam int TD = 3;
  localparam int NL = 32;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd3, reg_part = 2'd0, rd_sel = 2'd3;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] rd_data;
  logic [NT-1:0] fire = '0, lvl = '0, ie = '0;
  logic [NT-1:0][LW-1:0] route = '0;
  logic l0 = 1'b0, l1 = 1'b0;
  logic [NL-1:0] irq;
  logic leg_ena;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evt_main_ctrl #(.NUM_TMR(NT), .CNT_W(CW), .TICK_DIV(TD), .NUM_LINES(NL)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_part(reg_part),
    .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data), .tmr_fire(fire),
    .tmr_level(lvl), .tmr_int_en(ie), .tmr_route(route), .leg_in0(l0), .leg_in1(l1),
    .irq_line(irq), .leg_ena(leg_ena)
  );

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] part, input logic [CW-1:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_part = part; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [CW-1:0] v);
    rd_sel = sel;
    @(posedge clk); @(negedge clk);
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fire(input logic [NT-1:0] m);
    fire = m; @(negedge clk); fire = '0;
  endtask

  function automatic logic [NL-1:0] exp_lines(input logic [NT-1:0] st, input logic en,
      input logic lg, input logic [NT-1:0] ien, input logic [NT-1:0][LW-1:0] rt,
      input logic a, input logic b);
    logic [NL-1:0] r = '0;
    for (int t = 0; t < NT; t++) begin
      int dst = (lg && t == 0) ? 0 : (lg && t == 1) ? 8 : int'(rt[t]);
      if (st[t] && ien[t] && en) r[dst] = 1'b1;
    end
    if (!lg) begin r[0] = r[0] | a; r[8] = r[8] | b; end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired before all requirements were checked");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [CW-1:0] v, h, h2, hexp;
    int e, d, cap;
    logic [NT-1:0] m_st;
    logic m_en, m_lg;
    void'($urandom(32'd20240611));

    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R12 reset state
    rd(2'd0, v); chk("R12 cfg after reset", v, '0);
    rd(2'd2, v); chk("R12 counter after reset", v, '0);
    rd(2'd1, v); chk("R12 status after reset", v, '0);
    chk("R12 leg_ena after reset", CW'(leg_ena), CW'(1));
    chk("R12 lines after reset", CW'(irq), '0);

    // R1 reserved bits and upper-half write
    wr(2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFC);
    rd(2'd0, v); chk("R1 reserved bits read zero", v, '0);
    wr(2'd0, 2'd2, 64'h0000_0000_0000_0003);
    rd(2'd0, v); chk("R1 upper-half cfg write ignored", v, '0);

    // R4 half writes while halted
    wr(2'd2, 2'd1, 64'hAAAA_AAAA_FFFF_FFFE);
    wr(2'd2, 2'd2, 64'h0000_0001_5555_5555);
    rd(2'd2, v); h = 64'h0000_0001_FFFF_FFFE;
    chk("R4 half writes assemble counter", v, h);

    // R2 counting, crossing the 32-bit boundary
    wr(2'd0, 2'd1, 64'h1); e = cyc;
    rd_sel = 2'd2;
    repeat (14) @(posedge clk);
    @(negedge clk); cap = cyc;
    chk("R2 live count after enable", rd_data, h + CW'((cap - 1 - e) / TD));

    // R4 write while running does not alter count
    wr(2'd2, 2'd0, 64'h55);
    rd(2'd2, v); cap = cyc;
    chk("R4 running write ignored by live count", v, h + CW'((cap - 1 - e) / TD));

    // R3 disable holds
    wr(2'd0, 2'd1, 64'h0); d = cyc;
    hexp = h + CW'((d - 1 - e) / TD);
    rd(2'd2, v); chk("R3 held value after disable", v, hexp);
    idle(20);
    rd(2'd2, v); chk("R3 held value stays while halted", v, hexp);

    // R3 resume from held
    wr(2'd0, 2'd1, 64'h1); e = cyc; h2 = hexp;
    rd_sel = 2'd2;
    repeat (11) @(posedge clk);
    @(negedge clk); cap = cyc;
    chk("R3 resume continues from held", rd_data, h2 + CW'((cap - 1 - e) / TD));
    wr(2'd0, 2'd1, 64'h0);

    // Interrupt setup: t0,t2 level; t1,t3 edge
    route[0] = 5'd3; route[1] = 5'd5; route[2] = 5'd7; route[3] = 5'd7;
    ie = 4'hF; lvl = 4'b0101;
    wr(2'd0, 2'd1, 64'h1);
    pulse_fire(4'b0001); idle(2);
    rd(2'd1, v); chk("R5 level fire sets status", v, 64'h1);
    chk("R7 level line 3 high", CW'(irq[3]), CW'(1));
    pulse_fire(4'b0100); idle(2);
    chk("R7 timer 2 drives line 7", CW'(irq[7]), CW'(1));

    // R7 edge pulse on line 5, R5 no status
    fire = 4'b0010; @(negedge clk); fire = '0;
    chk("R7 edge line not yet", CW'(irq[5]), CW'(0));
    @(negedge clk);
    chk("R7 edge line pulses", CW'(irq[5]), CW'(1));
    @(negedge clk);
    chk("R7 edge pulse one cycle", CW'(irq[5]), CW'(0));
    rd(2'd1, v); chk("R5 edge fire leaves status", v, 64'h5);

    // R6 clear
    wr(2'd1, 2'd0, 64'h0);
    rd(2'd1, v); chk("R6 writing zero keeps status", v, 64'h5);
    wr(2'd1, 2'd0, 64'h1); idle(2);
    rd(2'd1, v); chk("R6 writing one clears bit", v, 64'h4);
    chk("R6 cleared line drops", CW'(irq[3]), CW'(0));

    // R8 enable rise re-asserts
    wr(2'd0, 2'd1, 64'h0); idle(2);
    chk("R8 line low while disabled", CW'(irq[7]), CW'(0));
    rd(2'd1, v); chk("R8 status kept while disabled", v, 64'h4);
    wr(2'd0, 2'd1, 64'h1); idle(2);
    chk("R8 line back after enable", CW'(irq[7]), CW'(1));

    // R10 pass-through
    wr(2'd1, 2'd0, 64'hF);
    l0 = 1'b1; l1 = 1'b1; idle(3);
    chk("R10 leg inputs pass to lines 0 and 8", CW'({irq[8], irq[0]}), CW'(3));

    // R9/R10/R11 legacy on
    wr(2'd0, 2'd1, 64'h3); idle(2);
    chk("R10 legacy masks inputs", CW'({irq[8], irq[0]}), CW'(0));
    chk("R11 leg_ena low in legacy", CW'(leg_ena), CW'(0));
    pulse_fire(4'b0001); idle(2);
    chk("R9 timer 0 to line 0 in legacy", CW'(irq[0]), CW'(1));
    chk("R9 timer 0 own route unused", CW'(irq[3]), CW'(0));
    fire = 4'b0010; @(negedge clk); fire = '0; @(negedge clk);
    chk("R9 timer 1 to line 8 in legacy", CW'(irq[8]), CW'(1));
    chk("R9 timer 1 own route unused", CW'(irq[5]), CW'(0));
    pulse_fire(4'b0100); idle(2);
    chk("R9 timer 2 keeps own route", CW'(irq[7]), CW'(1));
    wr(2'd1, 2'd0, 64'hF);
    l1 = 1'b0; idle(2);
    wr(2'd0, 2'd1, 64'h1); idle(2);
    chk("R10 line 8 restores latched low", CW'(irq[8]), CW'(0));
    chk("R11 leg_ena high after legacy", CW'(leg_ena), CW'(1));
    wr(2'd0, 2'd1, 64'h3); l1 = 1'b1; idle(2);
    wr(2'd0, 2'd1, 64'h1); idle(2);
    chk("R10 line 8 restores latched high", CW'(irq[8]), CW'(1));

    // Random steady-state phase
    wr(2'd1, 2'd0, 64'hF); m_st = '0;
    for (int it = 0; it < 60; it++) begin
      logic [NT-1:0] fm, cm;
      ie = NT'($urandom); lvl = NT'($urandom);
      for (int t = 0; t < NT; t++) route[t] = LW'($urandom % NL);
      l0 = 1'($urandom); l1 = 1'($urandom);
      m_en = 1'($urandom); m_lg = 1'($urandom);
      wr(2'd0, 2'd0, {62'h0, m_lg, m_en});
      fm = NT'($urandom);
      pulse_fire(fm);
      m_st = m_st | (fm & lvl);
      cm = NT'($urandom);
      wr(2'd1, 2'd0, CW'(cm));
      m_st = m_st & ~cm;
      idle(3);
      chk("R7 random line pattern", CW'(irq),
          CW'(exp_lines(m_st, m_en, m_lg, ie, route, l0, l1)));
      chk("R11 random leg_ena", CW'(leg_ena), CW'(!m_lg));
      rd(2'd1, v); chk("R6 random status", v, CW'(m_st));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule